// File: doc/BRIEF.md
# Run-Time Selectable Write-Policy Cache Controller

This block is a set-associative cache controller placed between a single word-wide requester and a slower backing memory that moves whole lines. For each set it keeps a directory of tag, valid and dirty bits, with one line of data per way. On a miss it stages the complete line. When every way of the set is occupied, it replaces the least recently used way. Before that line is overwritten, any modified contents are copied back to the backing memory.

A two-bit policy input chooses how writes are handled: write-around, write-through or deferred write-back. The policy decides whether a write miss allocates a line. It also decides what a write hit does. Under write-around the hit invalidates the line. Under write-through the line and the backing memory are both updated. Under write-back only the line is updated and marked modified. The requester issues one request at a time with a valid/ready handshake and receives a one-cycle response pulse. The backing side is a request/complete handshake with per-word write enables.

Top module: `wpc_ctrl`

## Requirements
- R1: After reset `req_ready_o` is high, `mem_valid_o` and `resp_valid_o` are low, and every line is invalid, so the first read of any address misses.
- R2: A read miss fetches the whole containing line (one backing read) before the addressed word is returned. A read hit returns the word with no backing traffic. An address is cached in at most one way.
- R3: Under write-around (`pol_i`=0) a write miss performs one backing write with only the addressed word enabled in `mem_be_o`, and stages no line, so a later read of that address misses.
- R4: Under write-around a write hit writes the backing memory and invalidates the cached line, so a later read of that address fetches the line again.
- R5: Under write-through (`pol_i`=1) a write miss first fetches the line, then writes the merged line to backing memory; the line stays cached afterwards.
- R6: Under write-through a write hit updates the cached line and the backing memory. The response comes only after the backing write has completed.
- R7: Under write-back (`pol_i`=2) a write hit updates only the cached line, with no backing traffic. The backing memory keeps its old value, and reads return the new value.
- R8: A further write-back write to a line that is already modified causes no backing traffic.
- R9: A modified victim is written in full to backing memory before the replacing line is fetched. After that write-back, the backing memory holds the modified data.
- R10: When all ways of a set are valid, a miss replaces the least recently used way. Every hit and every fill makes its way the most recently used.
- R11: The policy is captured when a request is accepted. A change on `pol_i` while that request is outstanding does not affect it.
- R12: Once `mem_valid_o` is raised, it and `mem_addr_o` and `mem_we_o` hold steady until `mem_ready_i` completes the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_i | input | 2 | Write policy: 0 around, 1 through, 2 back (3 acts as through) |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request accepted this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address {tag, set, word} |
| req_wdata_i | input | DATA_W | Write word |
| resp_valid_o | output | 1 | One-cycle completion pulse |
| resp_rdata_o | output | DATA_W | Read word (zero for writes) |
| mem_valid_o | output | 1 | Backing transfer requested |
| mem_ready_i | input | 1 | Backing transfer completes this cycle |
| mem_we_o | output | 1 | 1 = line write, 0 = line read |
| mem_addr_o | output | ADDR_W-log2(WORDS) | Line address {tag, set} |
| mem_be_o | output | WORDS | Per-word write enables |
| mem_wdata_o | output | WORDS*DATA_W | Line write data |
| mem_rdata_i | input | WORDS*DATA_W | Line read data, valid with mem_ready_i |

## Verification
A corrupted tag or valid bit shows up on the next access to that set. The port symptom is an unexpected backing read or a missing one, or a wrong word one cycle after the fill completes. A lost or spurious dirty bit stays hidden until the line is chosen as victim. It then appears as a missing or extra full-line backing write, or as stale data when the address is re-read after eviction. For that reason the sequences evict modified lines and read them back. A scrambled recency order shows up as the wrong way being replaced on the next miss to a full set. It is caught by re-reading both of the competing addresses.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    POL_AROUND  = 2'd0,
    POL_THROUGH = 2'd1,
    POL_BACK    = 2'd2
  } wpol_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TAG,
    S_EVICT,
    S_FILL,
    S_MWR
  } wst_e;
endpackage

// File: rtl/wpc_lru.sv
// Per-set recency list: position 0 holds the most recent way, the last
// position holds the replacement candidate.
module wpc_lru #(
  parameter int WAYS = 2,
  parameter int SETS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_i,
  input  logic             touch_en_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] lru_way_o
);
  logic [WAY_W-1:0] ord_q [SETS][WAYS];
  logic [WAY_W-1:0] row_d [WAYS];
  int               pos;

  always_comb begin
    pos = WAYS - 1;
    for (int p = 0; p < WAYS; p++)
      if (ord_q[set_i][p] == touch_way_i) pos = p;
    row_d[0] = touch_way_i;
    for (int p = 1; p < WAYS; p++)
      row_d[p] = (p <= pos) ? ord_q[set_i][p-1] : ord_q[set_i][p];
  end

  assign lru_way_o = ord_q[set_i][WAYS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int p = 0; p < WAYS; p++)
          ord_q[s][p] <= WAY_W'(p);
    end else if (touch_en_i) begin
      for (int p = 0; p < WAYS; p++)
        ord_q[set_i][p] <= row_d[p];
    end
  end

  logic [WAYS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int p = 0; p < WAYS; p++) seen[ord_q[set_i][p]] = 1'b1;
  end

  // R10
  order_perm_chk: assert property (@(posedge clk) disable iff (!rst_n) &seen);
endmodule

// File: rtl/wpc_store.sv
// Directory (tag/valid/dirty) and line storage with hit detection.
module wpc_store #(
  parameter int WAYS   = 2,
  parameter int SETS   = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  localparam int IDX_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  set_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              hit_o,
  output logic [WAY_W-1:0]  hit_way_o,
  output logic [WAYS-1:0]   vld_o,
  input  logic [WAY_W-1:0]  sel_way_i,
  output logic [LINE_W-1:0] sel_line_o,
  output logic [TAG_W-1:0]  sel_tag_o,
  output logic              sel_dirty_o,
  input  logic              fill_en_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              word_en_i,
  input  logic [OFF_W-1:0]  word_idx_i,
  input  logic [DATA_W-1:0] word_data_i,
  input  logic              word_dirty_i,
  input  logic              inval_en_i,
  input  logic              clean_en_i
);
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [LINE_W-1:0] line_q  [SETS][WAYS];
  logic [WAYS-1:0]   hit_vec;

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      hit_vec[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
  end

  assign hit_o       = |hit_vec;
  assign vld_o       = valid_q[set_i];
  assign sel_line_o  = line_q[set_i][sel_way_i];
  assign sel_tag_o   = tag_q[set_i][sel_way_i];
  assign sel_dirty_o = dirty_q[set_i][sel_way_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (fill_en_i) begin
        valid_q[set_i][sel_way_i] <= 1'b1;
        dirty_q[set_i][sel_way_i] <= 1'b0;
      end
      if (word_en_i)  dirty_q[set_i][sel_way_i] <= word_dirty_i;
      if (clean_en_i) dirty_q[set_i][sel_way_i] <= 1'b0;
      if (inval_en_i) begin
        valid_q[set_i][sel_way_i] <= 1'b0;
        dirty_q[set_i][sel_way_i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en_i) begin
      tag_q[set_i][sel_way_i]  <= tag_i;
      line_q[set_i][sel_way_i] <= fill_line_i;
    end
    if (word_en_i)
      line_q[set_i][sel_way_i][word_idx_i*DATA_W +: DATA_W] <= word_data_i;
  end

  // R2
  one_copy_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));

  // R9
  fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en_i |-> !(valid_q[set_i][sel_way_i] && dirty_q[set_i][sel_way_i]));
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WAYS   = 2,
  parameter int SETS   = 4,
  parameter int WORDS  = 4,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int LINE_W  = WORDS * DATA_W,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         pol_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_we_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               resp_valid_o,
  output logic [DATA_W-1:0]  resp_rdata_o,
  output logic               mem_valid_o,
  input  logic               mem_ready_i,
  output logic               mem_we_o,
  output logic [LADDR_W-1:0] mem_addr_o,
  output logic [WORDS-1:0]   mem_be_o,
  output logic [LINE_W-1:0]  mem_wdata_o,
  input  logic [LINE_W-1:0]  mem_rdata_i
);
  wst_e              st_q, st_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        pol_q;
  logic [WAY_W-1:0]  way_q, way_d;
  logic [LINE_W-1:0] buf_q, buf_d;
  logic [WORDS-1:0]  be_q, be_d;
  logic              resp_v_q, resp_v_d;
  logic [DATA_W-1:0] resp_d_q, resp_d_d;
  logic              accept;

  logic [IDX_W-1:0]  set;
  logic [TAG_W-1:0]  tag;
  logic [OFF_W-1:0]  off;
  logic              hit, sel_dirty;
  logic [WAY_W-1:0]  hit_way, lru_way, victim, pick_way;
  logic [WAYS-1:0]   vld;
  logic [LINE_W-1:0] sel_line, merged;
  logic [TAG_W-1:0]  sel_tag;
  logic [WORDS-1:0]  be_word;
  logic              fill_en, word_en, word_dirty, inval_en, clean_en, touch_en;

  assign set = addr_q[OFF_W +: IDX_W];
  assign tag = addr_q[ADDR_W-1 -: TAG_W];
  assign off = addr_q[OFF_W-1:0];

  wpc_store #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
    .clk, .rst_n, .set_i(set), .tag_i(tag), .hit_o(hit), .hit_way_o(hit_way), .vld_o(vld),
    .sel_way_i(pick_way), .sel_line_o(sel_line), .sel_tag_o(sel_tag), .sel_dirty_o(sel_dirty),
    .fill_en_i(fill_en), .fill_line_i(mem_rdata_i), .word_en_i(word_en), .word_idx_i(off),
    .word_data_i(wdata_q), .word_dirty_i(word_dirty), .inval_en_i(inval_en), .clean_en_i(clean_en)
  );

  wpc_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk, .rst_n, .set_i(set), .touch_en_i(touch_en), .touch_way_i(pick_way), .lru_way_o(lru_way)
  );

  always_comb begin
    victim = lru_way;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld[w]) victim = WAY_W'(w);
    pick_way = (st_q == S_TAG) ? (hit ? hit_way : victim) : way_q;
    merged = sel_line;
    merged[off*DATA_W +: DATA_W] = wdata_q;
    be_word = '0;
    be_word[off] = 1'b1;
  end

  always_comb begin
    st_d = st_q;  way_d = way_q;  buf_d = buf_q;  be_d = be_q;
    resp_v_d = 1'b0;  resp_d_d = resp_d_q;  accept = 1'b0;
    fill_en = 1'b0;  word_en = 1'b0;  word_dirty = 1'b0;
    inval_en = 1'b0;  clean_en = 1'b0;  touch_en = 1'b0;
    mem_valid_o = 1'b0;  mem_we_o = 1'b0;  mem_addr_o = {tag, set};
    mem_be_o = '0;  mem_wdata_o = buf_q;
    case (st_q)
      S_IDLE: if (req_valid_i) begin accept = 1'b1; st_d = S_TAG; end
      S_TAG: begin
        way_d = pick_way;
        if (hit && !we_q) begin
          resp_v_d = 1'b1;  resp_d_d = sel_line[off*DATA_W +: DATA_W];
          touch_en = 1'b1;  st_d = S_IDLE;
        end else if (we_q && pol_q == POL_AROUND) begin
          inval_en = hit;
          buf_d = hit ? merged : {WORDS{wdata_q}};
          be_d  = hit ? '1 : be_word;
          st_d  = S_MWR;
        end else if (hit) begin
          word_en = 1'b1;  touch_en = 1'b1;
          if (pol_q == POL_BACK) begin
            word_dirty = 1'b1;  resp_v_d = 1'b1;  resp_d_d = '0;  st_d = S_IDLE;
          end else begin
            buf_d = merged;  be_d = '1;  st_d = S_MWR;
          end
        end else begin
          st_d = (vld[victim] && sel_dirty) ? S_EVICT : S_FILL;
        end
      end
      S_EVICT: begin
        mem_valid_o = 1'b1;  mem_we_o = 1'b1;  mem_addr_o = {sel_tag, set};
        mem_be_o = '1;  mem_wdata_o = sel_line;
        if (mem_ready_i) begin clean_en = 1'b1; st_d = S_FILL; end
      end
      S_FILL: begin
        mem_valid_o = 1'b1;
        if (mem_ready_i) begin fill_en = 1'b1; touch_en = 1'b1; st_d = S_TAG; end
      end
      S_MWR: begin
        mem_valid_o = 1'b1;  mem_we_o = 1'b1;  mem_be_o = be_q;
        if (mem_ready_i) begin resp_v_d = 1'b1; resp_d_d = '0; st_d = S_IDLE; end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  we_q <= 1'b0;  addr_q <= '0;  wdata_q <= '0;  pol_q <= '0;
      way_q <= '0;  buf_q <= '0;  be_q <= '0;  resp_v_q <= 1'b0;  resp_d_q <= '0;
    end else begin
      st_q <= st_d;  way_q <= way_d;  buf_q <= buf_d;  be_q <= be_d;
      resp_v_q <= resp_v_d;  resp_d_q <= resp_d_d;
      if (accept) begin
        we_q <= req_we_i;  addr_q <= req_addr_i;  wdata_q <= req_wdata_i;  pol_q <= pol_i;
      end
    end
  end

  assign req_ready_o  = (st_q == S_IDLE);
  assign resp_valid_o = resp_v_q;
  assign resp_rdata_o = resp_d_q;

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R7
  wb_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_TAG && we_q && pol_q == POL_BACK && hit) |=> (resp_valid_o && !mem_valid_o));

  // R6
  wt_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && $past(we_q) && $past(pol_q) == POL_THROUGH) |-> $past(mem_valid_o && mem_ready_i && mem_we_o));

  // R3
  wa_nofill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FILL) |-> !(we_q && pol_q == POL_AROUND));
endmodule

// File: tb/tb_wpc_ctrl.sv
`timescale 1ns/1ps
module tb_wpc_ctrl;
  localparam int LAT = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   pol_i;
  logic         req_valid_i, req_ready_o, req_we_i;
  logic [11:0]  req_addr_i;
  logic [31:0]  req_wdata_i;
  logic         resp_valid_o;
  logic [31:0]  resp_rdata_o;
  logic         mem_valid_o, mem_ready_i, mem_we_o;
  logic [9:0]   mem_addr_o;
  logic [3:0]   mem_be_o;
  logic [127:0] mem_wdata_o, mem_rdata_i;

  wpc_ctrl dut (.*);

  always #2.5 clk = ~clk;

  logic [31:0] mem  [4096];
  logic [31:0] gold [4096];
  int n_chk = 0, n_err = 0, n_rd = 0, n_wr = 0, n_resp = 0, lat_cnt;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  // backing memory model
  assign mem_ready_i = mem_valid_o && (lat_cnt == LAT);
  always_comb
    for (int w = 0; w < 4; w++) mem_rdata_i[w*32 +: 32] = mem[{mem_addr_o, 2'(w)}];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_cnt <= 0;
    else if (mem_valid_o) begin
      if (lat_cnt == LAT) begin
        lat_cnt <= 0;
        if (mem_we_o) begin
          for (int w = 0; w < 4; w++)
            if (mem_be_o[w]) mem[{mem_addr_o, 2'(w)}] <= mem_wdata_o[w*32 +: 32];
          n_wr <= n_wr + 1;
        end else n_rd <= n_rd + 1;
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  // handshake hold monitor (R12)
  logic       hold_q = 1'b0;
  logic [9:0] hold_addr;
  int         hs_bad = 0;
  always @(negedge clk) begin
    if (rst_n && hold_q && !(mem_valid_o && mem_addr_o == hold_addr)) hs_bad++;
    hold_q    <= rst_n && mem_valid_o && !mem_ready_i;
    hold_addr <= mem_addr_o;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid_o) begin
      if (exp_q.size() == 0) check(1'b0, "unexpected response", resp_rdata_o, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(resp_rdata_o == e, {t, " response data"}, resp_rdata_o, e);
      end
      n_resp++;
    end
  end

  function automatic logic [11:0] ad(input int t, input int s, input int o);
    return 12'(t * 16 + s * 4 + o);
  endfunction

  task automatic op(input bit we, input logic [11:0] a, input logic [31:0] wd,
                    input logic [1:0] pol, input logic [1:0] pol_after,
                    input int erd, input int ewr, input string r);
    int rd0, wr0, rs0;
    @(negedge clk);
    exp_q.push_back(we ? 32'h0 : gold[a]);
    tag_q.push_back(r);
    if (we) gold[a] = wd;
    rd0 = n_rd; wr0 = n_wr; rs0 = n_resp;
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = a; req_wdata_i = wd; pol_i = pol;
    @(negedge clk);
    req_valid_i = 1'b0; pol_i = pol_after;
    while (n_resp == rs0) @(negedge clk);
    check(n_rd - rd0 == erd, {r, " backing reads"}, 32'(n_rd - rd0), 32'(erd));
    check(n_wr - wr0 == ewr, {r, " backing writes"}, 32'(n_wr - wr0), 32'(ewr));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish actual=hang expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [11:0] x, y, z, w, v, u;
    for (int i = 0; i < 4096; i++) begin
      mem[i]  = 32'hA500_0000 | 32'(i);
      gold[i] = 32'hA500_0000 | 32'(i);
    end
    x = ad(1, 1, 2); y = ad(2, 1, 0); z = ad(3, 1, 1); w = ad(4, 1, 3);
    v = ad(5, 2, 1); u = ad(6, 3, 3);
    rst_n = 1'b0; pol_i = 2'd2; req_valid_i = 1'b0; req_we_i = 1'b0;
    req_addr_i = '0; req_wdata_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready_o == 1'b1, "R1 ready in reset", 32'(req_ready_o), 32'h1);
    check(mem_valid_o == 1'b0, "R1 no backing request in reset", 32'(mem_valid_o), 32'h0);
    check(resp_valid_o == 1'b0, "R1 no response in reset", 32'(resp_valid_o), 32'h0);
    rst_n = 1'b1;

    op(0, x, 0, 2, 2, 1, 0, "R1 R2 cold read miss");
    op(0, x, 0, 2, 2, 0, 0, "R2 read hit");
    op(1, x, 32'hDEAD_0001, 2, 2, 0, 0, "R7 write-back hit");
    check(mem[x] == (32'hA500_0000 | 32'(x)), "R7 backing unchanged", mem[x], 32'hA500_0000 | 32'(x));
    op(1, x, 32'hDEAD_0002, 2, 2, 0, 0, "R8 rewrite dirty line");
    op(0, x, 0, 2, 2, 0, 0, "R7 read new data");

    op(0, y, 0, 2, 2, 1, 0, "R10 fill free way");
    op(0, x, 0, 2, 2, 0, 0, "R10 touch x");
    op(0, z, 0, 2, 2, 1, 0, "R10 miss replaces y");
    op(0, x, 0, 2, 2, 0, 0, "R10 x kept");
    op(0, y, 0, 2, 2, 1, 0, "R10 y was evicted");
    op(0, w, 0, 2, 2, 1, 1, "R9 dirty victim written back");
    check(mem[x] == 32'hDEAD_0002, "R9 backing holds dirty data", mem[x], 32'hDEAD_0002);
    op(0, x, 0, 2, 2, 1, 0, "R9 refetch evicted line");

    op(1, x, 32'h1111_0000, 1, 1, 0, 1, "R6 write-through hit");
    check(mem[x] == 32'h1111_0000, "R6 backing updated", mem[x], 32'h1111_0000);
    op(0, x, 0, 1, 1, 0, 0, "R6 line still cached");

    op(1, v, 32'h5555_0000, 1, 1, 1, 1, "R5 write-through miss allocates");
    check(mem[v] == 32'h5555_0000, "R5 backing updated", mem[v], 32'h5555_0000);
    op(0, v, 0, 1, 1, 0, 0, "R5 line cached after miss");

    op(1, u, 32'h6666_0000, 0, 0, 0, 1, "R3 write-around miss");
    check(mem[u] == 32'h6666_0000, "R3 backing word written", mem[u], 32'h6666_0000);
    check(mem[u-1] == (32'hA500_0000 | 32'(u-1)), "R3 neighbour word untouched",
          mem[u-1], 32'hA500_0000 | 32'(u-1));
    op(0, u, 0, 0, 0, 1, 0, "R3 no line staged");

    op(1, x, 32'h2222_0000, 0, 0, 0, 1, "R4 write-around hit");
    check(mem[x] == 32'h2222_0000, "R4 backing updated", mem[x], 32'h2222_0000);
    op(0, x, 0, 0, 0, 1, 0, "R4 line invalidated");

    op(1, x, 32'h3333_0000, 2, 0, 0, 0, "R11 policy held during request");
    check(mem[x] == 32'h2222_0000, "R11 backing not written", mem[x], 32'h2222_0000);
    op(0, x, 0, 0, 0, 0, 0, "R11 read back");

    check(hs_bad == 0, "R12 handshake held steady", 32'(hs_bad), 32'h0);
    check(exp_q.size() == 0, "R2 all responses received", 32'(exp_q.size()), 32'h0);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule